// File: doc/BRIEF.md
# FIR Block-Run Sequencer

This controller drives a filter datapath across a complete stored block of samples. When an idle controller sees a start request, it reads the sample memory one word per cycle from address 0 up to the last entry. It passes each returned word to the datapath. Its write side stays quiet for a fixed number of cycles while the pipeline fills, so the outputs produced before the pipeline holds real data are never stored. After that, it writes one result per cycle into the result memory at consecutive addresses, starting at 0.

The fill length is a parameter. It equals the datapath latency plus the single cycle that the sample memory takes to return a read. With this value, the result computed from the sample at address k is written at address k. After the final sample has been read, the read address stays at the last entry and the datapath receives zero words. This continues until every result slot has been written. The controller then raises its ready flag and goes back to waiting. The memories and the arithmetic sit outside this block.

Top module: `fir_run_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller returns to idle. After that edge `rd_en`, `wr_en` and `rdy` are 0 and `dp_sample` is 0.
- R2: When `start` is sampled high in idle, the next cycle has `rd_en` = 1, `rd_addr` = 0, `wr_en` = 0 and `rdy` = 0.
- R3: During a run, `rd_addr` rises by one per cycle from 0 to DEPTH-1, with `rd_en` high for exactly DEPTH cycles. `rd_addr` then holds at DEPTH-1 with `rd_en` low.
- R4: `wr_en` stays 0 for the first FILL cycles of a run. Cycle 0 is the cycle after `start` is accepted.
- R5: `wr_en` is 1 from cycle FILL through cycle FILL+DEPTH-1, and `wr_addr` steps by one from 0 to DEPTH-1 over that span.
- R6: With a datapath of latency FILL-1, the result derived from the sample at read address k is written at result address k, for every k.
- R7: `dp_sample` equals `mem_q` in the cycle after a read was issued. It is 0 in the cycle after a cycle with `rd_en` low.
- R8: `rdy` rises in cycle FILL+DEPTH, and the controller is idle then. `rdy` stays high until the next `start` is accepted.
- R9: A `start` that arrives while a run is in progress has no effect on addresses, enables or completion timing.
- R10: While `rdy` is high, `rd_en` and `wr_en` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Run request, active high, honoured only when idle |
| rd_en | output | 1 | Sample memory read enable |
| rd_addr | output | ADDR_W | Sample memory read address |
| mem_q | input | DATA_W | Word returned by the sample memory one cycle after a read |
| dp_sample | output | DATA_W | Sample presented to the datapath; zero when no read was issued |
| wr_en | output | 1 | Result memory write enable |
| wr_addr | output | ADDR_W | Result memory write address |
| rdy | output | 1 | Run complete, active high |

## Verification
The assertions check the per-cycle rules on every cycle: the stepping of both address counters, the quiet enables while `rdy` is high, the zero feed after an idle read slot, the launch cycle after an accepted start, and that a run cannot be left on a stray `start`. Only the bench's scenarios can show the end-to-end alignment of R6. To do so, the bench models a memory and a delay-line datapath and checks that every slot of the result memory holds the word from the matching sample address. The exact cycles at which writing begins and `rdy` rises, and the effect of a reset in the middle of a run, are also left to the scenarios.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_FILL = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic clr;
        logic step;
    } cnt_ctl_t;

    // Bits needed to hold values 0..limit (at least one bit)
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter
    import fir_seq_pkg::*;
#(
    parameter int LIMIT = 1,
    localparam int W = cnt_width(LIMIT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_ctl_t     ctl,
    output logic [W-1:0] cnt,
    output logic         at_lim
);

    assign at_lim = (cnt == W'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ctl.clr)
            cnt <= '0;
        else if (ctl.step && !at_lim)
            cnt <= cnt + 1'b1;
    end

    // R3/R5: a counter at its limit stays there until cleared
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_lim && !ctl.clr) |=> at_lim);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import fir_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_done,
    input  logic       fill_done,
    input  logic       wr_done,
    output seq_state_e state,
    output logic       accept,
    output logic       reading,
    output logic       rdy
);

    assign accept = (state == SEQ_IDLE) && start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            reading <= 1'b0;
            rdy     <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_FILL;
                    rdy   <= 1'b0;
                end
                SEQ_FILL: if (fill_done) state <= SEQ_RUN;
                SEQ_RUN: if (wr_done) begin
                    state <= SEQ_IDLE;
                    rdy   <= 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase

            if (accept)
                reading <= 1'b1;
            else if (reading && rd_done)
                reading <= 1'b0;
        end
    end

    // R8: rdy is only ever seen while idle
    p_rdy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (state == SEQ_IDLE));

endmodule

// File: rtl/fir_run_seq.sv
module fir_run_seq
    import fir_seq_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int FILL   = 19,
    parameter int DATA_W = 32,
    localparam int ADDR_W = cnt_width(DEPTH - 1),
    localparam int FILL_LIM = (FILL > 0) ? FILL - 1 : 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] mem_q,
    output logic [DATA_W-1:0] dp_sample,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rdy
);

    localparam int NCNT = 3;
    localparam int C_RD = 0;
    localparam int C_FL = 1;
    localparam int C_WR = 2;

    seq_state_e state;
    logic       accept;
    logic       reading;
    logic       zero_q;
    logic       busy;

    cnt_ctl_t   ctl    [NCNT];
    logic       lim    [NCNT];

    logic [ADDR_W-1:0]              rd_cnt;
    logic [ADDR_W-1:0]              wr_cnt;
    logic [cnt_width(FILL_LIM)-1:0] fill_cnt;

    assign busy = (state != SEQ_IDLE);

    assign ctl[C_RD] = '{clr: accept, step: reading};
    assign ctl[C_FL] = '{clr: accept, step: (state == SEQ_FILL)};
    assign ctl[C_WR] = '{clr: accept, step: (state == SEQ_RUN)};

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            if (g == C_FL) begin : g_fill
                seq_counter #(.LIMIT(FILL_LIM)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .ctl(ctl[g]),
                    .cnt(fill_cnt), .at_lim(lim[g]));
            end else if (g == C_RD) begin : g_rd
                seq_counter #(.LIMIT(DEPTH - 1)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .ctl(ctl[g]),
                    .cnt(rd_cnt), .at_lim(lim[g]));
            end else begin : g_wr
                seq_counter #(.LIMIT(DEPTH - 1)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .ctl(ctl[g]),
                    .cnt(wr_cnt), .at_lim(lim[g]));
            end
        end
    endgenerate

    seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_done  (lim[C_RD]),
        .fill_done(lim[C_FL] && (state == SEQ_FILL)),
        .wr_done  (lim[C_WR] && (state == SEQ_RUN)),
        .state    (state),
        .accept   (accept),
        .reading  (reading),
        .rdy      (rdy)
    );

    // Zero feed: the sample slot is empty when no read was issued last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) zero_q <= 1'b1;
        else        zero_q <= !reading;
    end

    assign rd_en     = reading;
    assign rd_addr   = rd_cnt;
    assign wr_en     = (state == SEQ_RUN);
    assign wr_addr   = wr_cnt;
    assign dp_sample = zero_q ? '0 : mem_q;

    // R3: read address advances by one while reading
    p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != ADDR_W'(DEPTH - 1))
            |=> (rd_en && rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    // R5: write address advances by one while writing
    p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(DEPTH - 1))
            |=> (wr_en && wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R2: accepted start launches the read sweep at address 0
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (rd_en && rd_addr == '0 && !wr_en && !rdy));

    // R7: empty read slot yields a zero sample
    p_zero_feed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (dp_sample == '0));

    // R8: final write is followed by ready
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(DEPTH - 1)) |=> (rdy && !busy));

    // R9: a start during a run does not end or restart it
    p_busy_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(wr_en && wr_addr == ADDR_W'(DEPTH - 1)))
            |=> (busy && !rdy));

    // R10: no memory traffic while ready
    p_rdy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (!rd_en && !wr_en));

endmodule

// File: tb/test_fir_run_seq.sv
`timescale 1ns/1ps
module test_fir_run_seq;

    localparam int DEPTH  = 16;
    localparam int FILL   = 4;
    localparam int LAT    = FILL - 1;
    localparam int DATA_W = 32;
    localparam int AW     = 4;
    localparam int LAST_T = FILL + DEPTH;

    typedef struct packed {
        logic [7:0]  t;
        logic [3:0]  req;
        logic        rd;
        logic [7:0]  ra;
        logic        wr;
        logic [7:0]  wa;
        logic        rdy;
    } vec_t;

    // Expected port values at selected cycles of a run (cycle 0 = after start accepted)
    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{t: 8'd0,  req: 4'd2, rd: 1'b1, ra: 8'd0,  wr: 1'b0, wa: 8'd0,  rdy: 1'b0}, // R2
        '{t: 8'd3,  req: 4'd4, rd: 1'b1, ra: 8'd3,  wr: 1'b0, wa: 8'd0,  rdy: 1'b0}, // R4
        '{t: 8'd4,  req: 4'd5, rd: 1'b1, ra: 8'd4,  wr: 1'b1, wa: 8'd0,  rdy: 1'b0}, // R5
        '{t: 8'd15, req: 4'd3, rd: 1'b1, ra: 8'd15, wr: 1'b1, wa: 8'd11, rdy: 1'b0}, // R3
        '{t: 8'd16, req: 4'd3, rd: 1'b0, ra: 8'd15, wr: 1'b1, wa: 8'd12, rdy: 1'b0}, // R3
        '{t: 8'd19, req: 4'd5, rd: 1'b0, ra: 8'd15, wr: 1'b1, wa: 8'd15, rdy: 1'b0}, // R5
        '{t: 8'd20, req: 4'd8, rd: 1'b0, ra: 8'd15, wr: 1'b0, wa: 8'd15, rdy: 1'b1}  // R8
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] dp_sample;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic              rdy;

    logic [DATA_W-1:0] dline [LAT];
    logic [DATA_W-1:0] res_mem [DEPTH];

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    fir_run_seq #(.DEPTH(DEPTH), .FILL(FILL), .DATA_W(DATA_W)) i_fir_run_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr), .mem_q(mem_q), .dp_sample(dp_sample),
        .wr_en(wr_en), .wr_addr(wr_addr), .rdy(rdy));

    // Sample memory model: word at address a is 0x100 + a, one-cycle read
    always_ff @(posedge clk) begin
        if (rd_en) mem_q <= 32'h100 + 32'(rd_addr);
    end

    // Datapath model: pure delay of LAT cycles
    always_ff @(posedge clk) begin
        dline[0] <= dp_sample;
        for (int i = 1; i < LAT; i++) dline[i] <= dline[i-1];
    end

    // Result memory model
    always_ff @(posedge clk) begin
        if (wr_en) res_mem[wr_addr] <= dline[LAT-1];
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_res();
        for (int k = 0; k < DEPTH; k++) res_mem[k] = 32'hDEAD_0000;
    endtask

    // One run: start accepted, walk the table; optional stray start at cycle 6
    task automatic run(input bit stray);
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        for (int t = 0; t <= LAST_T; t++) begin
            @(negedge clk);
            start = (stray && t == 6) ? 1'b1 : 1'b0;
            for (int v = 0; v < NV; v++) begin
                if (int'(TBL[v].t) == t) begin
                    string r;
                    r = $sformatf("R%0d", TBL[v].req);
                    chk(r, int'(rd_en),   int'(TBL[v].rd),  $sformatf("rd_en t=%0d", t));
                    chk(r, int'(rd_addr), int'(TBL[v].ra),  $sformatf("rd_addr t=%0d", t));
                    chk(r, int'(wr_en),   int'(TBL[v].wr),  $sformatf("wr_en t=%0d", t));
                    chk(r, int'(wr_addr), int'(TBL[v].wa),  $sformatf("wr_addr t=%0d", t));
                    chk(r, int'(rdy),     int'(TBL[v].rdy), $sformatf("rdy t=%0d", t));
                end
            end
            if (t == 5)  chk("R7", int'(dp_sample), 32'h104, "sample after read of 4");
            if (t == 17) chk("R7", int'(dp_sample), 0, "zero feed after sweep");
        end
        // R6: each result slot holds the word from the matching sample address
        for (int k = 0; k < DEPTH; k++)
            chk("R6", int'(res_mem[k]), 32'h100 + k, $sformatf("result slot %0d", k));
    endtask

    initial begin
        clear_res();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(rd_en), 0, "rd_en in reset");
        chk("R1", int'(wr_en), 0, "wr_en in reset");
        chk("R1", int'(rdy), 0, "rdy in reset");
        chk("R1", int'(dp_sample), 0, "dp_sample in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(1'b0);

        // R8: rdy holds while idle
        repeat (3) @(negedge clk);
        chk("R8", int'(rdy), 1, "rdy held in idle");
        chk("R10", int'(rd_en | wr_en), 0, "no traffic while ready");

        // R9: stray start during run; same timeline and results
        clear_res();
        run(1'b1);

        // R1: reset in the middle of a run
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        repeat (7) @(negedge clk);
        chk("R5", int'(wr_en), 1, "writing before mid-run reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", int'(rd_en), 0, "rd_en after mid-run reset");
        chk("R1", int'(wr_en), 0, "wr_en after mid-run reset");
        chk("R1", int'(rdy), 0, "rdy after mid-run reset");
        repeat (4) @(negedge clk);
        chk("R1", int'(wr_en | rd_en), 0, "stays idle after reset");

        // Fresh run after reset still aligns
        clear_res();
        run(1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule